// File: doc/BRIEF.md
# Latched Parallel-In Serial-Out Shifter

This block turns an 8-bit parallel word into a serial bit stream. A staging latch sits in front of the shift chain. A capture strobe copies the parallel inputs into the latch. A mode input then decides what the shift chain does. In load mode it copies the latch. In shift mode each shift strobe moves the chain one stage towards the output, and a serial input fills the first stage. The serial output is always the last stage of the chain.

Both strobes are asynchronous level inputs. Each passes through a two-stage synchronizer on the single system clock, and its rising edge becomes a one-cycle event. Reset is split in two. The active-low asynchronous reset clears only the shift chain. A separate power-on reset clears the staging latch and the strobe synchronizers synchronously. A captured word therefore survives a reset issued in the middle of a shift, and can be loaded and sent again.

Top module: `latched_piso`

## Requirements
- R1: A rising edge on `cap_strobe_i` stores `par_i` into the staging latch on the third rising clock edge after the strobe goes high.
- R2: While `shift_mode_i` is 0 (load mode), the shift chain copies the staging latch on every clock edge, so `ser_o` equals bit 7 of the latch one edge after the latch changes.
- R3: While `shift_mode_i` is 1 (shift mode), each rising edge of `shift_strobe_i` shifts the chain once, on the third clock edge after the strobe goes high. Stage 0 takes `ser_i` and stage k takes stage k-1. `ser_o` is stage 7, so a loaded word leaves most significant bit (`par_i[7]`) first.
- R4: In load mode, `ser_i` and `shift_strobe_i` have no effect on the shift chain.
- R5: When `rst_ni` is low, all shift stages clear to 0 at once, without waiting for a clock edge, and `ser_o` reads 0.
- R6: `rst_ni` leaves the staging latch unchanged, so a later load brings back the word captured before the reset.
- R7: When `por_ni` is low at a clock edge, the staging latch clears to 0.
- R8: If a capture event and a load happen on the same edge, the chain receives the old latch value on that edge and the new value on the next edge.
- R9: A strobe held high produces exactly one event. A strobe must return low before it can produce another event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low clear of the shift chain |
| por_ni | input | 1 | Synchronous active-low power-on clear of the latch and synchronizers |
| par_i | input | 8 | Parallel data word |
| cap_strobe_i | input | 1 | Capture strobe; its rising edge stores `par_i` into the latch |
| shift_strobe_i | input | 1 | Shift strobe; its rising edge advances the chain in shift mode |
| shift_mode_i | input | 1 | 0 = load from latch, 1 = serial shift |
| ser_i | input | 1 | Serial input into stage 0 |
| ser_o | output | 1 | Serial output, the last stage |

## Verification
A strobe that goes high before clock edge 1 takes effect on edge 3: two edges pass through the synchronizer and the edge-detect register holds one more. In load mode the chain follows the latch one edge later still, so a capture appears on `ser_o` after edge 4. The behavioural model in the bench keeps this same three-edge event delay. It is compared with `ser_o` a quarter period after every edge. The directed checks wait a fixed number of edges before they sample, except the reset check, which samples between edges to show that the clear needs no clock.

// File: rtl/latched_piso_pkg.sv
package latched_piso_pkg;
  localparam int unsigned DEF_WIDTH       = 8;
  localparam int unsigned DEF_SYNC_STAGES = 2;

  typedef enum logic {
    MODE_LOAD  = 1'b0,
    MODE_SHIFT = 1'b1
  } chain_mode_e;
endpackage

// File: rtl/latched_piso_edge.sv
module latched_piso_edge #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic por_ni,
  input  logic strobe_i,
  output logic pulse_o
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  for (genvar g = 0; g < STAGES; g++) begin : g_sync
    if (g == 0) begin : g_first
      always_ff @(posedge clk_i) begin
        if (!por_ni) sync_q[0] <= 1'b0;
        else         sync_q[0] <= strobe_i;
      end
    end else begin : g_next
      always_ff @(posedge clk_i) begin
        if (!por_ni) sync_q[g] <= 1'b0;
        else         sync_q[g] <= sync_q[g-1];
      end
    end
  end

  always_ff @(posedge clk_i) begin
    if (!por_ni) prev_q <= 1'b0;
    else         prev_q <= sync_q[STAGES-1];
  end

  assign pulse_o = sync_q[STAGES-1] & ~prev_q;

  // one event per strobe rise
  p_single_pulse_r9: assert property (@(posedge clk_i) disable iff (!por_ni)
    pulse_o |=> !pulse_o)
    else $error("p_single_pulse_r9");
endmodule

// File: rtl/latched_piso_latch.sv
module latched_piso_latch #(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk_i,
  input  logic             por_ni,
  input  logic             cap_pulse_i,
  input  logic [WIDTH-1:0] par_i,
  output logic [WIDTH-1:0] latch_o
);
  always_ff @(posedge clk_i) begin
    if (!por_ni)          latch_o <= '0;
    else if (cap_pulse_i) latch_o <= par_i;
  end

  p_latch_hold_r6: assert property (@(posedge clk_i) disable iff (!por_ni)
    !cap_pulse_i |=> $stable(latch_o))
    else $error("p_latch_hold_r6");

  p_latch_take_r1: assert property (@(posedge clk_i) disable iff (!por_ni)
    cap_pulse_i |=> latch_o == $past(par_i))
    else $error("p_latch_take_r1");
endmodule

// File: rtl/latched_piso_chain.sv
module latched_piso_chain
  import latched_piso_pkg::*;
#(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  chain_mode_e      mode_i,
  input  logic             shift_pulse_i,
  input  logic [WIDTH-1:0] latch_i,
  input  logic             ser_i,
  output logic [WIDTH-1:0] chain_o
);
  logic [WIDTH-1:0] chain_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  chain_q <= '0;
    else if (mode_i == MODE_LOAD) chain_q <= latch_i;
    else if (shift_pulse_i)       chain_q <= {chain_q[WIDTH-2:0], ser_i};
  end

  assign chain_o = chain_q;

  p_load_copy_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == MODE_LOAD) |=> chain_q == $past(latch_i))
    else $error("p_load_copy_r2");

  p_shift_step_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == MODE_SHIFT && shift_pulse_i) |=>
      (chain_q[0] == $past(ser_i)) && (chain_q[WIDTH-1:1] == $past(chain_q[WIDTH-2:0])))
    else $error("p_shift_step_r3");

  p_idle_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == MODE_SHIFT && !shift_pulse_i) |=> $stable(chain_q))
    else $error("p_idle_hold_r4");
endmodule

// File: rtl/latched_piso.sv
module latched_piso
  import latched_piso_pkg::*;
#(
  parameter int unsigned WIDTH       = DEF_WIDTH,
  parameter int unsigned SYNC_STAGES = DEF_SYNC_STAGES
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             por_ni,
  input  logic [WIDTH-1:0] par_i,
  input  logic             cap_strobe_i,
  input  logic             shift_strobe_i,
  input  logic             shift_mode_i,
  input  logic             ser_i,
  output logic             ser_o
);
  localparam int unsigned LAST = WIDTH - 1;

  logic             cap_pulse;
  logic             shift_pulse;
  logic [WIDTH-1:0] latch_q;
  logic [WIDTH-1:0] chain_q;
  chain_mode_e      mode;

  assign mode = chain_mode_e'(shift_mode_i);

  latched_piso_edge #(.STAGES(SYNC_STAGES)) u_cap_edge (
    .clk_i    (clk_i),
    .por_ni   (por_ni),
    .strobe_i (cap_strobe_i),
    .pulse_o  (cap_pulse)
  );

  latched_piso_edge #(.STAGES(SYNC_STAGES)) u_shift_edge (
    .clk_i    (clk_i),
    .por_ni   (por_ni),
    .strobe_i (shift_strobe_i),
    .pulse_o  (shift_pulse)
  );

  latched_piso_latch #(.WIDTH(WIDTH)) u_latch (
    .clk_i       (clk_i),
    .por_ni      (por_ni),
    .cap_pulse_i (cap_pulse),
    .par_i       (par_i),
    .latch_o     (latch_q)
  );

  latched_piso_chain #(.WIDTH(WIDTH)) u_chain (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .mode_i        (mode),
    .shift_pulse_i (shift_pulse),
    .latch_i       (latch_q),
    .ser_i         (ser_i),
    .chain_o       (chain_q)
  );

  assign ser_o = chain_q[LAST];

  p_reset_clear_r5: assert property (@(posedge clk_i)
    !rst_ni |-> ser_o == 1'b0)
    else $error("p_reset_clear_r5");

  p_por_clear_r7: assert property (@(posedge clk_i)
    !por_ni |=> latch_q == '0)
    else $error("p_por_clear_r7");
endmodule

// File: tb/latched_piso_tb.sv
module latched_piso_tb;
  localparam int CLK_PERIOD = 10;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0, por_n = 1'b0;
  logic [W-1:0] par = '0;
  logic         cap = 1'b0, shf = 1'b0, mode = 1'b0, sin = 1'b0;
  logic         ser;

  int n_chk = 0, n_fail = 0;
  bit started = 1'b0;
  string cur_req = "R2";

  // behavioural model state
  logic [W-1:0] m_latch = '0, m_sr = '0;
  bit cap_h[3], shf_h[3];

  always #(CLK_PERIOD/2) clk = ~clk;

  latched_piso u_dut (
    .clk_i(clk), .rst_ni(rst_n), .por_ni(por_n), .par_i(par),
    .cap_strobe_i(cap), .shift_strobe_i(shf), .shift_mode_i(mode),
    .ser_i(sin), .ser_o(ser)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s at %0t: ser_o=%b expected %b", req, $time, act, exp);
    end
  endtask

  // model: strobe event three edges after the input rises
  always @(posedge clk) begin
    bit cp, sp;
    cp = cap_h[1] && !cap_h[2];
    sp = shf_h[1] && !shf_h[2];
    if (!rst_n)      m_sr = '0;
    else if (!mode)  m_sr = m_latch;
    else if (sp)     m_sr = {m_sr[W-2:0], sin};
    if (!por_n) begin
      m_latch = '0;
      foreach (cap_h[i]) begin cap_h[i] = 1'b0; shf_h[i] = 1'b0; end
    end else begin
      if (cp) m_latch = par;
      cap_h[2] = cap_h[1]; cap_h[1] = cap_h[0]; cap_h[0] = cap;
      shf_h[2] = shf_h[1]; shf_h[1] = shf_h[0]; shf_h[0] = shf;
    end
  end
  always @(negedge rst_n) m_sr = '0;

  always @(posedge clk) begin
    #(CLK_PERIOD/4);
    if (started) chk({"model/", cur_req}, ser, m_sr[W-1]);
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic capture(input logic [W-1:0] b);
    par = b; cap = 1'b1; cyc(2); cap = 1'b0; cyc(4);
  endtask

  task automatic load_word();
    mode = 1'b0; cyc(2);
  endtask

  task automatic shift_out(input logic [W-1:0] b, input logic [W-1:0] fill, input int n);
    mode = 1'b1; cyc(1);
    for (int i = 0; i < n; i++) begin
      chk("R3", ser, b[W-1-i]);
      sin = fill[i]; shf = 1'b1; cyc(2); shf = 1'b0; cyc(3);
    end
  endtask

  initial begin
    cyc(3);
    chk("R5", ser, 1'b0);
    rst_n = 1'b1; por_n = 1'b1; started = 1'b1;
    cyc(2);
    chk("R5", ser, 1'b0);

    cur_req = "R1";
    capture(8'hA5);
    chk("R2", ser, 1'b1);

    cur_req = "R3";
    for (int k = 0; k < 6; k++) begin
      logic [W-1:0] b, f;
      b = W'($urandom); f = W'($urandom);
      capture(b); load_word();
      shift_out(b, f, W);
      chk("R3", ser, f[0]);
    end

    cur_req = "R4";
    capture(8'h3C); load_word();
    for (int k = 0; k < 3; k++) begin
      sin = ~sin; shf = 1'b1; cyc(2); shf = 1'b0; cyc(3);
      chk("R4", ser, 1'b0);
    end
    shift_out(8'h3C, 8'hFF, W);

    cur_req = "R6";
    capture(8'hD2); load_word();
    shift_out(8'hD2, 8'h00, 3);
    #1 rst_n = 1'b0;
    #1 chk("R5", ser, 1'b0);
    cyc(2); rst_n = 1'b1; cyc(1);
    chk("R5", ser, 1'b0);
    load_word();
    shift_out(8'hD2, 8'h55, W);

    cur_req = "R8";
    capture(8'h0F); load_word();
    par = 8'hF0; cap = 1'b1;
    repeat (3) @(posedge clk);
    #2 chk("R8", ser, 1'b0);
    @(posedge clk);
    #2 chk("R8", ser, 1'b1);
    cyc(1); cap = 1'b0; cyc(4);

    cur_req = "R9";
    capture(8'h96); load_word();
    mode = 1'b1; shf = 1'b1; cyc(20);
    chk("R9", ser, 1'b0);
    shf = 1'b0; cyc(4);
    chk("R9", ser, 1'b0);

    cur_req = "R7";
    capture(8'hFF);
    por_n = 1'b0; cyc(2); por_n = 1'b1;
    load_word(); cyc(1);
    chk("R7", ser, 1'b0);
    shift_out(8'h00, 8'h00, W);

    finish_run();
  end

  task automatic finish_run();
    started = 1'b0;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: run did not finish, expected completion");
    finish_run();
  end
endmodule